// File: doc/BRIEF.md
# Shared Global Spare Allocator

This block hands out spare repair units to fault positions reported by any layer of a stacked memory. All spare units sit in one repair layer and are shared by every memory layer; none is tied to a layer or a group of layers. A spare becomes a row segment or a column segment only at the moment it is allocated. Its segment starts at any row or column the faults call for, and it covers `GRID` consecutive positions. Byte columns are the unit. A second pool of spares, the cylinders, each replace one (row, column) position in every layer at once.

Faults arrive as a layer mask plus a row and a column. A mask with two or more layers set means the same position failed in several layers during a parallel test, and it claims a cylinder. A mask with one layer set is a single fault. The first uncovered single fault is parked in a one-entry hold register. The next fault then decides the shape of the spare: a shared row gives a row segment, a shared column gives a column segment, and otherwise the parked fault takes a row segment. A lookup port answers, one cycle later, whether a (layer, row, column) access is redirected, whether the target is a cylinder, and which spare it is.

Top module: `gsa_alloc`

## Requirements
- R1: After reset no spare or cylinder is in use, the hold register is empty, `lk_hit`, `lk_cyl`, `lk_idx` are 0 and `repair_fail` is 0.
- R2: A single-layer fault (exactly one `flt_mask` bit set) that no spare or cylinder covers, arriving while the hold register is empty, is parked and allocates nothing, so a lookup of that position still misses.
- R3: A single-layer fault in the same layer and row as the parked fault, with column distance below `GRID`, allocates a row segment on that layer and row that starts at the smaller of the two columns and covers `GRID` columns. The hold register is then emptied.
- R4: Otherwise, a single-layer fault in the same layer and column as the parked fault, with row distance below `GRID`, allocates a column segment that starts at the smaller row and covers `GRID` rows. The hold register is then emptied.
- R5: Any other uncovered single-layer fault gives the parked fault a row segment starting at its column, and the new fault is parked. `flush` with `flt_valid` low gives a parked fault a row segment starting at its column. `flush` is ignored while `flt_valid` is high.
- R6: A single-layer fault already covered by a segment of the same layer, or by a cylinder at that exact position, consumes no spare and is not parked.
- R7: A fault whose mask has two or more bits set allocates the lowest free cylinder at (row, column), unless a cylinder already sits there. A cylinder hits a lookup from any layer at exactly that position.
- R8: Spare units are one pool for all layers: each allocation takes the lowest-numbered free unit, whatever the layer, and at most one unit is allocated per cycle.
- R9: `lk_hit`, `lk_cyl`, `lk_idx` reflect the request of the previous cycle. A cylinder hit wins over a segment hit, and among several hits the lowest index wins. With `lk_valid` low, or on a miss, all three are 0.
- R10: When an allocation finds no free unit of the needed kind, nothing is allocated and `repair_fail` rises and stays high until reset.
- R11: A segment covers only positions from its start up to start+`GRID`-1. It never wraps past the array edge and never covers a position below its start.
- R12: A lookup made in the same cycle as an allocation sees the table as it was before that allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | Fault report present |
| flt_mask | input | LAYERS | Layers in which the position failed |
| flt_row | input | log2(DIM) | Fault row |
| flt_col | input | log2(DIM) | Fault byte column |
| flush | input | 1 | Allocate the parked fault |
| lk_valid | input | 1 | Lookup request |
| lk_layer | input | log2(LAYERS) | Lookup layer |
| lk_row | input | log2(DIM) | Lookup row |
| lk_col | input | log2(DIM) | Lookup byte column |
| lk_hit | output | 1 | Previous lookup is redirected |
| lk_cyl | output | 1 | Redirect target is a cylinder |
| lk_idx | output | log2(NSPARE) | Index of the spare or cylinder |
| repair_fail | output | 1 | Sticky: a fault could not be covered |

## Verification
Allocation and lookup can land in the same cycle. The bench provokes this by sending the fault that completes a row pair, or a new cylinder, together with a lookup of the very position being repaired. The reference model computes the lookup answer from its table before it applies that cycle's allocation, so a miss is expected in that cycle and a hit on the next request. The same comparison also judges cylinder priority when a cylinder lands on a position that a segment already covers.

// File: rtl/gsa_pkg.sv
package gsa_pkg;

    typedef enum logic {
        SEG_ROW = 1'b0,
        SEG_COL = 1'b1
    } seg_kind_e;

    function automatic logic [15:0] gsa_absdiff(input logic [15:0] a, input logic [15:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/gsa_pick.sv
module gsa_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/gsa_cover.sv
module gsa_cover #(
    parameter int N    = 8,
    parameter int LW   = 3,
    parameter int AW   = 10,
    parameter int GRID = 4
) (
    input  logic [N-1:0]         used_i,
    input  logic [N-1:0]         is_col_i,
    input  logic [N-1:0][LW-1:0] layer_i,
    input  logic [N-1:0][AW-1:0] line_i,
    input  logic [N-1:0][AW-1:0] start_i,
    input  logic [LW-1:0]        q_layer,
    input  logic [AW-1:0]        q_row,
    input  logic [AW-1:0]        q_col,
    output logic [N-1:0]         hit_o
);
    localparam logic [AW:0] SPAN = (AW + 1)'(GRID);

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic          on_line;
        logic [AW-1:0] pos;
        logic [AW:0]   off;
        assign on_line  = is_col_i[g] ? (line_i[g] == q_col) : (line_i[g] == q_row);
        assign pos      = is_col_i[g] ? q_row : q_col;
        assign off      = {1'b0, pos} - {1'b0, start_i[g]};
        assign hit_o[g] = used_i[g] && (layer_i[g] == q_layer) && on_line
                          && !off[AW] && (off < SPAN);
    end
endmodule

// File: rtl/gsa_alloc.sv
module gsa_alloc
    import gsa_pkg::*;
#(
    parameter int LAYERS = 8,
    parameter int DIM    = 1024,
    parameter int GRID   = 4,
    parameter int NSPARE = 8,
    parameter int NCYL   = 2,
    localparam int LW    = $clog2(LAYERS),
    localparam int AW    = $clog2(DIM),
    localparam int IW    = $clog2(NSPARE),
    localparam int CIW   = $clog2(NCYL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic [LAYERS-1:0] flt_mask,
    input  logic [AW-1:0]     flt_row,
    input  logic [AW-1:0]     flt_col,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [LW-1:0]     lk_layer,
    input  logic [AW-1:0]     lk_row,
    input  logic [AW-1:0]     lk_col,
    output logic              lk_hit,
    output logic              lk_cyl,
    output logic [IW-1:0]     lk_idx,
    output logic              repair_fail
);
    typedef struct packed {
        logic          used;
        seg_kind_e     kind;
        logic [LW-1:0] layer;
        logic [AW-1:0] line;
        logic [AW-1:0] start;
    } spare_t;

    typedef struct packed {
        logic          used;
        logic [AW-1:0] row;
        logic [AW-1:0] col;
    } cyl_t;

    typedef struct packed {
        logic          valid;
        logic [LW-1:0] layer;
        logic [AW-1:0] row;
        logic [AW-1:0] col;
    } hold_t;

    typedef struct packed {
        spare_t [NSPARE-1:0] sp;
        cyl_t   [NCYL-1:0]   cy;
        hold_t               hold;
        logic                fail;
        logic                lk_hit;
        logic                lk_cyl;
        logic [IW-1:0]       lk_idx;
    } state_t;

    state_t st_d, st_q;

    // field views of the spare table for the coverage units
    logic [NSPARE-1:0]         sp_used, sp_iscol;
    logic [NSPARE-1:0][LW-1:0] sp_layer;
    logic [NSPARE-1:0][AW-1:0] sp_line, sp_start;
    logic [NCYL-1:0]           cy_used, cy_fhit, cy_lhit;

    for (genvar g = 0; g < NSPARE; g++) begin : g_view
        assign sp_used[g]  = st_q.sp[g].used;
        assign sp_iscol[g] = (st_q.sp[g].kind == SEG_COL);
        assign sp_layer[g] = st_q.sp[g].layer;
        assign sp_line[g]  = st_q.sp[g].line;
        assign sp_start[g] = st_q.sp[g].start;
    end

    for (genvar g = 0; g < NCYL; g++) begin : g_cyl
        assign cy_used[g] = st_q.cy[g].used;
        assign cy_fhit[g] = st_q.cy[g].used && st_q.cy[g].row == flt_row && st_q.cy[g].col == flt_col;
        assign cy_lhit[g] = st_q.cy[g].used && st_q.cy[g].row == lk_row && st_q.cy[g].col == lk_col;
    end

    // fault decode
    logic [LW-1:0] f_layer;
    int            f_count;
    always_comb begin
        f_layer = '0;
        f_count = $countones(flt_mask);
        for (int i = 0; i < LAYERS; i++) begin
            if (flt_mask[i]) f_layer = LW'(i);
        end
    end

    logic [NSPARE-1:0] f_sp_hit, l_sp_hit;

    gsa_cover #(.N(NSPARE), .LW(LW), .AW(AW), .GRID(GRID)) u_fcov (
        .used_i(sp_used), .is_col_i(sp_iscol), .layer_i(sp_layer),
        .line_i(sp_line), .start_i(sp_start),
        .q_layer(f_layer), .q_row(flt_row), .q_col(flt_col), .hit_o(f_sp_hit)
    );

    gsa_cover #(.N(NSPARE), .LW(LW), .AW(AW), .GRID(GRID)) u_lcov (
        .used_i(sp_used), .is_col_i(sp_iscol), .layer_i(sp_layer),
        .line_i(sp_line), .start_i(sp_start),
        .q_layer(lk_layer), .q_row(lk_row), .q_col(lk_col), .hit_o(l_sp_hit)
    );

    logic          sp_free_ok, cy_free_ok, l_sp_ok, l_cy_ok;
    logic [IW-1:0] sp_free_idx, l_sp_idx;
    logic [CIW-1:0] cy_free_idx, l_cy_idx;

    gsa_pick #(.N(NSPARE), .IW(IW)) u_sp_free (.req(~sp_used), .found(sp_free_ok), .idx(sp_free_idx));
    gsa_pick #(.N(NCYL), .IW(CIW)) u_cy_free (.req(~cy_used), .found(cy_free_ok), .idx(cy_free_idx));
    gsa_pick #(.N(NSPARE), .IW(IW)) u_l_sp (.req(l_sp_hit), .found(l_sp_ok), .idx(l_sp_idx));
    gsa_pick #(.N(NCYL), .IW(CIW)) u_l_cy (.req(cy_lhit), .found(l_cy_ok), .idx(l_cy_idx));

    // next-state computation
    logic          a_req, c_req;
    seg_kind_e     a_kind;
    logic [LW-1:0] a_layer;
    logic [AW-1:0] a_line, a_start;
    logic          f_single, f_multi, f_covered, same_row, same_col;

    always_comb begin
        st_d    = st_q;
        a_req   = 1'b0;
        c_req   = 1'b0;
        a_kind  = SEG_ROW;
        a_layer = st_q.hold.layer;
        a_line  = st_q.hold.row;
        a_start = st_q.hold.col;

        f_single  = flt_valid && (f_count == 1);
        f_multi   = flt_valid && (f_count >= 2);
        f_covered = (|f_sp_hit) || (|cy_fhit);
        same_row  = st_q.hold.valid && st_q.hold.layer == f_layer && st_q.hold.row == flt_row
                    && gsa_absdiff(16'(flt_col), 16'(st_q.hold.col)) < 16'(GRID);
        same_col  = st_q.hold.valid && st_q.hold.layer == f_layer && st_q.hold.col == flt_col
                    && gsa_absdiff(16'(flt_row), 16'(st_q.hold.row)) < 16'(GRID);

        // lookup against the table as registered
        st_d.lk_hit = 1'b0;
        st_d.lk_cyl = 1'b0;
        st_d.lk_idx = '0;
        if (lk_valid) begin
            if (l_cy_ok) begin
                st_d.lk_hit = 1'b1;
                st_d.lk_cyl = 1'b1;
                st_d.lk_idx = IW'(l_cy_idx);
            end else if (l_sp_ok) begin
                st_d.lk_hit = 1'b1;
                st_d.lk_idx = l_sp_idx;
            end
        end

        // fault handling
        if (f_multi) begin
            c_req = !(|cy_fhit);
        end else if (f_single && !f_covered) begin
            if (!st_q.hold.valid) begin
                st_d.hold = '{valid: 1'b1, layer: f_layer, row: flt_row, col: flt_col};
            end else if (same_row) begin
                a_req   = 1'b1;
                a_start = (flt_col < st_q.hold.col) ? flt_col : st_q.hold.col;
                st_d.hold.valid = 1'b0;
            end else if (same_col) begin
                a_req   = 1'b1;
                a_kind  = SEG_COL;
                a_line  = st_q.hold.col;
                a_start = (flt_row < st_q.hold.row) ? flt_row : st_q.hold.row;
                st_d.hold.valid = 1'b0;
            end else begin
                a_req     = 1'b1;
                st_d.hold = '{valid: 1'b1, layer: f_layer, row: flt_row, col: flt_col};
            end
        end else if (!flt_valid && flush && st_q.hold.valid) begin
            a_req = 1'b1;
            st_d.hold.valid = 1'b0;
        end

        if (a_req) begin
            if (sp_free_ok) begin
                st_d.sp[sp_free_idx] = '{used: 1'b1, kind: a_kind, layer: a_layer,
                                         line: a_line, start: a_start};
            end else begin
                st_d.fail = 1'b1;
            end
        end

        if (c_req) begin
            if (cy_free_ok) begin
                st_d.cy[cy_free_idx] = '{used: 1'b1, row: flt_row, col: flt_col};
            end else begin
                st_d.fail = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_hit      = st_q.lk_hit;
    assign lk_cyl      = st_q.lk_cyl;
    assign lk_idx      = st_q.lk_idx;
    assign repair_fail = st_q.fail;

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        repair_fail |=> repair_fail); // R10
    AST_LK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_hit && !lk_cyl); // R9
    AST_CYL_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_cyl |-> lk_hit); // R9
    AST_USED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sp_used & $past(sp_used)) == $past(sp_used)); // R8
    AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(sp_used ^ $past(sp_used)) <= 1); // R8
    AST_COVERED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && $countones(flt_mask) == 1 && ((|f_sp_hit) || (|cy_fhit)))
        |=> $stable(sp_used) && $stable(cy_used)); // R6

endmodule

// File: tb/sim_gsa_alloc.sv
module sim_gsa_alloc;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 8, G = 4, NSP = 8, NCY = 2;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       flt_valid = 0, flush = 0, lk_valid = 0;
    logic [7:0] flt_mask = '0;
    logic [9:0] flt_row = '0, flt_col = '0, lk_row = '0, lk_col = '0;
    logic [2:0] lk_layer = '0;
    logic       lk_hit, lk_cyl, repair_fail;
    logic [2:0] lk_idx;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gsa_alloc u0 (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_mask(flt_mask),
        .flt_row(flt_row), .flt_col(flt_col), .flush(flush), .lk_valid(lk_valid),
        .lk_layer(lk_layer), .lk_row(lk_row), .lk_col(lk_col), .lk_hit(lk_hit),
        .lk_cyl(lk_cyl), .lk_idx(lk_idx), .repair_fail(repair_fail)
    );

    // behavioural reference state
    bit m_used[NSP]; bit m_iscol[NSP]; int m_layer[NSP]; int m_line[NSP]; int m_start[NSP];
    bit m_cu[NCY]; int m_cr[NCY]; int m_cc[NCY];
    bit h_v; int h_l, h_r, h_c;
    bit m_fail;

    function automatic bit seg_cov(int i, int l, int r, int c);
        int pos, ln;
        if (!m_used[i] || m_layer[i] != l) return 0;
        ln  = m_iscol[i] ? c : r;
        pos = m_iscol[i] ? r : c;
        return (ln == m_line[i]) && (pos >= m_start[i]) && (pos < m_start[i] + G);
    endfunction

    function automatic bit cyl_cov(int r, int c);
        for (int k = 0; k < NCY; k++) if (m_cu[k] && m_cr[k] == r && m_cc[k] == c) return 1;
        return 0;
    endfunction

    task automatic m_alloc(bit iscol, int l, int line, int st);
        for (int k = 0; k < NSP; k++) begin
            if (!m_used[k]) begin
                m_used[k] = 1; m_iscol[k] = iscol; m_layer[k] = l; m_line[k] = line; m_start[k] = st;
                return;
            end
        end
        m_fail = 1;
    endtask

    function automatic int absd(int a, int b);
        return a > b ? a - b : b - a;
    endfunction

    task automatic step(string tag, bit fv, logic [7:0] fm, int fr, int fc, bit fl,
                        bit lv, int ll, int lr, int lc);
        bit eh, ec; logic [2:0] ei; int n, fly; bit cov, done;
        flt_valid = fv; flt_mask = fm; flt_row = 10'(fr); flt_col = 10'(fc); flush = fl;
        lk_valid = lv; lk_layer = 3'(ll); lk_row = 10'(lr); lk_col = 10'(lc);
        eh = 0; ec = 0; ei = 0;
        if (lv) begin
            done = 0;
            for (int k = 0; k < NCY && !done; k++)
                if (m_cu[k] && m_cr[k] == lr && m_cc[k] == lc) begin eh = 1; ec = 1; ei = 3'(k); done = 1; end
            for (int k = 0; k < NSP && !done; k++)
                if (seg_cov(k, ll, lr, lc)) begin eh = 1; ei = 3'(k); done = 1; end
        end
        n = $countones(fm); fly = 0;
        for (int i = 0; i < NL; i++) if (fm[i]) fly = i;
        if (fv && n >= 2) begin
            if (!cyl_cov(fr, fc)) begin
                done = 0;
                for (int k = 0; k < NCY && !done; k++)
                    if (!m_cu[k]) begin m_cu[k] = 1; m_cr[k] = fr; m_cc[k] = fc; done = 1; end
                if (!done) m_fail = 1;
            end
        end else if (fv && n == 1) begin
            cov = cyl_cov(fr, fc);
            for (int k = 0; k < NSP; k++) if (seg_cov(k, fly, fr, fc)) cov = 1;
            if (!cov) begin
                if (!h_v) begin h_v = 1; h_l = fly; h_r = fr; h_c = fc; end
                else if (h_l == fly && h_r == fr && absd(fc, h_c) < G) begin
                    m_alloc(0, fly, fr, fc < h_c ? fc : h_c); h_v = 0;
                end else if (h_l == fly && h_c == fc && absd(fr, h_r) < G) begin
                    m_alloc(1, fly, fc, fr < h_r ? fr : h_r); h_v = 0;
                end else begin
                    m_alloc(0, h_l, h_r, h_c); h_l = fly; h_r = fr; h_c = fc;
                end
            end
        end else if (!fv && fl && h_v) begin
            m_alloc(0, h_l, h_r, h_c); h_v = 0;
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (lk_hit !== eh || lk_cyl !== ec || lk_idx !== ei || repair_fail !== m_fail) begin
            errors++;
            $display("FAIL %s: hit/cyl/idx/fail actual %b/%b/%0d/%b expected %b/%b/%0d/%b",
                     tag, lk_hit, lk_cyl, lk_idx, repair_fail, eh, ec, ei, m_fail);
        end
    endtask

    task automatic flt(string tag, logic [7:0] m, int r, int c);
        step(tag, 1, m, r, c, 0, 0, 0, 0, 0);
    endtask

    task automatic look(string tag, int l, int r, int c);
        step(tag, 0, 8'h00, 0, 0, 0, 1, l, r, c);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (lk_hit !== 0 || lk_cyl !== 0 || lk_idx !== 0 || repair_fail !== 0) begin
            errors++;
            $display("FAIL R1: actual %b/%b/%0d/%b expected 0/0/0/0", lk_hit, lk_cyl, lk_idx, repair_fail);
        end
        rst_n = 1'b1;
        look("R1 empty table", 0, 0, 0);
        // R2 parked fault
        step("R2 park", 1, 8'h04, 5, 10, 0, 1, 2, 5, 10);
        look("R2 still parked", 2, 5, 10);
        // R3 row pairing at unaligned start 10
        flt("R3 pair", 8'h04, 5, 12);
        look("R3 row hit", 2, 5, 13);
        look("R11 below start", 2, 5, 9);
        look("R11 past end", 2, 5, 14);
        // R4 column pairing
        flt("R4 park", 8'h08, 100, 7);
        flt("R4 pair", 8'h08, 102, 7);
        look("R4 col hit", 3, 103, 7);
        look("R4 col end", 3, 104, 7);
        look("R4 other layer", 2, 101, 7);
        // R6 covered fault, then R5 spill and flush
        flt("R6 covered", 8'h04, 5, 11);
        flt("R5 park", 8'h02, 0, 1021);
        flt("R5 spill", 8'h40, 40, 40);
        look("R5 spill hit", 1, 0, 1023);
        look("R11 no wrap", 1, 0, 0);
        step("R5 flush ignored", 1, 8'h00, 0, 0, 1, 1, 6, 40, 40);
        step("R5 flush", 0, 8'h00, 0, 0, 1, 0, 0, 0, 0);
        look("R5 flush hit", 6, 40, 43);
        // R12 same-cycle lookup and allocation
        flt("R12 park", 8'h10, 60, 60);
        step("R12 same cycle", 1, 8'h10, 60, 61, 0, 1, 4, 60, 61);
        look("R12 after", 4, 60, 61);
        // R7 cylinder
        step("R7 alloc", 1, 8'h11, 200, 300, 0, 1, 7, 200, 300);
        look("R7 any layer", 7, 200, 300);
        look("R7 exact position", 7, 200, 301);
        flt("R6 cylinder covered", 8'h20, 200, 300);
        flt("R6 next park", 8'h20, 250, 250);
        look("R6 no spill spare", 5, 200, 301);
        // R9 priority
        flt("R9 second cylinder", 8'h06, 5, 11);
        look("R9 cylinder first", 2, 5, 11);
        look("R9 segment", 2, 5, 12);
        look("R9 no request", 0, 0, 0);
        step("R9 idle", 0, 8'h00, 0, 0, 0, 0, 2, 5, 12);
        // R8 fill pool across layers
        flt("R8 pair L5", 8'h20, 250, 251);
        flt("R8 park L7", 8'h80, 10, 10);
        flt("R8 pair L7", 8'h80, 11, 10);
        flt("R8 park L0", 8'h01, 1, 1);
        flt("R8 pair L0", 8'h01, 1, 2);
        look("R8 last unit", 0, 1, 4);
        look("R8 col unit", 7, 13, 10);
        // R10 exhaustion
        flt("R10 park", 8'h01, 900, 900);
        flt("R10 no unit", 8'h01, 900, 901);
        look("R10 not allocated", 0, 900, 900);
        flt("R10 cylinder", 8'h03, 7, 7);
        step("R10 sticky", 0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule